// File: doc/BRIEF.md
# Variable Range Overlap Scanner

This block checks a bank of variable memory-range descriptors for conflicts. Each descriptor is a pair of 64-bit words: a base word that gives the first page of the range, and a mask word that gives the range size and carries an enable bit. After a start pulse the scanner reads every active descriptor through an indexed read port. It converts each one into inclusive page bounds and keeps them in a small local table. It then compares every unordered pair of descriptors, one pair per clock. It stops at the first conflict, or after the last pair.

When the scan ends, `done` pulses for one cycle and `overlap` reports the result. `overlap` keeps its value until the next accepted start. The number of descriptors to scan comes from the low byte of a capability word, which is sampled when a start is accepted. The read port is combinational: `rd_idx` is valid while `rd_en` is high, and the data must come back in the same cycle. The port has no back-pressure. The scanner reads one index per cycle and never stalls.

Top module: `range_overlap_scanner`

## Requirements
- R1: A descriptor is enabled only when bit 11 of its mask word is 1. A disabled descriptor is empty, with both bounds zero, and never conflicts with anything.
- R2: The first page of a range is base word bits [PA_W-1:12]. The size in pages is 2^(PA_W-12) minus mask bits [PA_W-1:12], so an all-zero mask field covers 2^(PA_W-12) pages. The last page is first page + size - 1, computed one bit wider so that it cannot wrap.
- R3: The descriptor count is `cap_word[7:0]`, sampled when a start is accepted and clamped to MAX_RANGES. With a count below 2 there are no pairs and `overlap` stays 0.
- R4: Pairs are visited with outer index i from 0 and inner index j from i+1 to count-1. Each unordered pair is compared once, and the scan ends at the first conflicting pair.
- R5: Two enabled ranges conflict when a first or last page of either one lies inside the other's inclusive [first, last] interval. Ranges that touch at a single page conflict. Ranges that are only adjacent do not.
- R6: `done` is high for exactly one cycle per scan. `overlap` is cleared on the edge that accepts a start, and it then holds the scan result from the `done` cycle until the next accepted start.
- R7: A start is accepted only while `busy` is 0. `busy` is high from the accepting edge through the `done` cycle. A start seen while `busy` is 1 has no effect.
- R8: Counting the accepting edge as edge 1, `done` rises on edge count+2+p, where p is the visit-order index of the terminating pair. If no pair conflicts, p is count*(count-1)/2-1. With a count below 2, `done` rises on edge 1.
- R9: After reset, `busy`, `done`, `overlap` and `rd_en` are all 0.
- R10: During a scan with a count of at least 2, `rd_en` is high for exactly count consecutive cycles, and `rd_idx` steps through 0 to count-1. With a count below 2, no reads are made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan request, accepted only while idle |
| cap_word | input | 32 | Capability word; the low byte is the descriptor count |
| rd_en | output | 1 | Read strobe for the descriptor bank |
| rd_idx | output | $clog2(MAX_RANGES) | Descriptor index being read |
| rd_base | input | WORD_W | Base word of descriptor `rd_idx`, same cycle |
| rd_mask | input | WORD_W | Mask word of descriptor `rd_idx`, same cycle |
| busy | output | 1 | Scan in progress, through the done cycle |
| done | output | 1 | One-cycle end-of-scan pulse |
| overlap | output | 1 | A conflict was found in the last scan |

## Verification
The cases hardest to reach from the ports are those where the answer depends on exact bound arithmetic. These are ranges that share exactly one page, ranges that are adjacent, and a descriptor with an all-zero mask field that spans the whole page space. Each must be set up in the bench's descriptor bank with chosen base and mask words. Early termination can only be seen through timing, so every scan is predicted with the index of its terminating pair and its expected `done` edge, and the measured latency is compared. Extra start pulses are also driven in the middle of scans, and the bench checks that no additional `done` appears and that the latency is unchanged.

// File: rtl/overlap_scan_pkg.sv
package overlap_scan_pkg;
  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_LOAD = 2'd1,
    SC_CMP  = 2'd2,
    SC_DONE = 2'd3
  } scan_state_t;
endpackage

// File: rtl/ovs_span_decode.sv
module ovs_span_decode #(
  parameter int WORD_W     = 64,
  parameter int PA_W       = 36,
  parameter int PAGE_SHIFT = 12,
  parameter int VALID_BIT  = 11,
  localparam int PG_W      = PA_W - PAGE_SHIFT
) (
  input  logic [WORD_W-1:0] base_word,
  input  logic [WORD_W-1:0] mask_word,
  output logic              span_vld,
  output logic [PG_W:0]     span_lo,
  output logic [PG_W:0]     span_hi
);
  logic [PG_W-1:0] first_pg;
  logic [PG_W-1:0] mask_pg;
  logic [PG_W:0]   size_pg;
  logic [PG_W:0]   last_pg;
  logic            unused_bits;

  assign first_pg = base_word[PA_W-1:PAGE_SHIFT];
  assign mask_pg  = mask_word[PA_W-1:PAGE_SHIFT];
  // bits above the address width read as ones, so negation is 2^PG_W - field
  assign size_pg  = {1'b1, {PG_W{1'b0}}} - {1'b0, mask_pg};
  assign last_pg  = {1'b0, first_pg} + size_pg - {{PG_W{1'b0}}, 1'b1};

  always_comb begin
    span_vld = mask_word[VALID_BIT];
    span_lo  = '0;
    span_hi  = '0;
    if (span_vld) begin
      span_lo = {1'b0, first_pg};
      span_hi = last_pg;
    end
  end

  assign unused_bits = ^{base_word, mask_word};
endmodule

// File: rtl/ovs_span_table.sv
module ovs_span_table #(
  parameter int MAX_RANGES = 8,
  parameter int PG_W       = 24,
  localparam int IDX_W     = $clog2(MAX_RANGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [PG_W:0]    wr_lo,
  input  logic [PG_W:0]    wr_hi,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_vld,
  output logic [PG_W:0]    a_lo,
  output logic [PG_W:0]    a_hi,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_vld,
  output logic [PG_W:0]    b_lo,
  output logic [PG_W:0]    b_hi
);
  logic            vld_m [MAX_RANGES];
  logic [PG_W:0]   lo_m  [MAX_RANGES];
  logic [PG_W:0]   hi_m  [MAX_RANGES];

  for (genvar e = 0; e < MAX_RANGES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_m[e] <= 1'b0;
        lo_m[e]  <= '0;
        hi_m[e]  <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        vld_m[e] <= wr_vld;
        lo_m[e]  <= wr_lo;
        hi_m[e]  <= wr_hi;
      end
    end
  end

  assign a_vld = vld_m[a_idx];
  assign a_lo  = lo_m[a_idx];
  assign a_hi  = hi_m[a_idx];
  assign b_vld = vld_m[b_idx];
  assign b_lo  = lo_m[b_idx];
  assign b_hi  = hi_m[b_idx];
endmodule

// File: rtl/ovs_pair_walker.sv
module ovs_pair_walker #(
  parameter int MAX_RANGES = 8,
  localparam int IDX_W     = $clog2(MAX_RANGES),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] idx_j,
  output logic             last
);
  logic j_end;

  assign j_end = ({1'b0, idx_j} == (cnt - CNT_W'(1)));
  assign last  = j_end && ({1'b0, idx_i} == (cnt - CNT_W'(2)));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_i <= '0;
      idx_j <= '0;
    end else if (init) begin
      idx_i <= '0;
      idx_j <= IDX_W'(1);
    end else if (step && !last) begin
      if (j_end) begin
        idx_i <= idx_i + IDX_W'(1);
        idx_j <= idx_i + IDX_W'(2);
      end else begin
        idx_j <= idx_j + IDX_W'(1);
      end
    end
  end

  // R4: inner index always strictly above outer and inside the count
  assert_pair_order_R4: assert property (@(posedge clk) disable iff (rst)
    step |-> (idx_j > idx_i));
  assert_pair_bound_R4: assert property (@(posedge clk) disable iff (rst)
    step |-> ({1'b0, idx_j} < cnt));
endmodule

// File: rtl/ovs_span_compare.sv
module ovs_span_compare #(
  parameter int PG_W = 24
) (
  input  logic          a_vld,
  input  logic [PG_W:0] a_lo,
  input  logic [PG_W:0] a_hi,
  input  logic          b_vld,
  input  logic [PG_W:0] b_lo,
  input  logic [PG_W:0] b_hi,
  output logic          hit
);
  logic b_lo_in_a, b_hi_in_a, a_lo_in_b, a_hi_in_b;

  assign b_lo_in_a = (b_lo >= a_lo) && (b_lo <= a_hi);
  assign b_hi_in_a = (b_hi >= a_lo) && (b_hi <= a_hi);
  assign a_lo_in_b = (a_lo >= b_lo) && (a_lo <= b_hi);
  assign a_hi_in_b = (a_hi >= b_lo) && (a_hi <= b_hi);

  assign hit = a_vld && b_vld &&
               (b_lo_in_a || b_hi_in_a || a_lo_in_b || a_hi_in_b);
endmodule

// File: rtl/range_overlap_scanner.sv
module range_overlap_scanner #(
  parameter int WORD_W     = 64,
  parameter int PA_W       = 36,
  parameter int PAGE_SHIFT = 12,
  parameter int VALID_BIT  = 11,
  parameter int MAX_RANGES = 8,
  localparam int PG_W      = PA_W - PAGE_SHIFT,
  localparam int IDX_W     = $clog2(MAX_RANGES),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       cap_word,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_base,
  input  logic [WORD_W-1:0] rd_mask,
  output logic              busy,
  output logic              done,
  output logic              overlap
);
  import overlap_scan_pkg::*;

  scan_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_new;
  logic [IDX_W-1:0] k_q;
  logic             ovl_q;
  logic             accept, load_last, few;
  logic [7:0]       cap_lo;
  logic             unused_cap;

  logic             dec_vld;
  logic [PG_W:0]    dec_lo, dec_hi;
  logic             a_vld, b_vld;
  logic [PG_W:0]    a_lo, a_hi, b_lo, b_hi;
  logic [IDX_W-1:0] idx_i, idx_j;
  logic             pair_last, hit;

  assign cap_lo     = cap_word[7:0];
  assign unused_cap = ^cap_word[31:8];
  assign cnt_new    = (cap_lo > 8'(MAX_RANGES)) ? CNT_W'(MAX_RANGES)
                                                : cap_lo[CNT_W-1:0];
  assign few        = (cap_lo < 8'd2);
  assign accept     = start && (state_q == SC_IDLE);
  assign load_last  = ({1'b0, k_q} == (cnt_q - CNT_W'(1)));

  always_comb begin
    state_d = state_q;
    case (state_q)
      SC_IDLE: if (start) state_d = few ? SC_DONE : SC_LOAD;
      SC_LOAD: if (load_last) state_d = SC_CMP;
      SC_CMP:  if (hit || pair_last) state_d = SC_DONE;
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SC_IDLE;
      cnt_q   <= '0;
      k_q     <= '0;
      ovl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cnt_q <= cnt_new;
        k_q   <= '0;
        ovl_q <= 1'b0;
      end else begin
        if (state_q == SC_LOAD) k_q <= k_q + IDX_W'(1);
        if ((state_q == SC_CMP) && hit) ovl_q <= 1'b1;
      end
    end
  end

  assign rd_en   = (state_q == SC_LOAD);
  assign rd_idx  = k_q;
  assign busy    = (state_q != SC_IDLE);
  assign done    = (state_q == SC_DONE);
  assign overlap = ovl_q;

  ovs_span_decode #(
    .WORD_W(WORD_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .VALID_BIT(VALID_BIT)
  ) u_decode (
    .base_word(rd_base), .mask_word(rd_mask),
    .span_vld(dec_vld), .span_lo(dec_lo), .span_hi(dec_hi)
  );

  ovs_span_table #(.MAX_RANGES(MAX_RANGES), .PG_W(PG_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(rd_en), .wr_idx(k_q), .wr_vld(dec_vld), .wr_lo(dec_lo), .wr_hi(dec_hi),
    .a_idx(idx_i), .a_vld(a_vld), .a_lo(a_lo), .a_hi(a_hi),
    .b_idx(idx_j), .b_vld(b_vld), .b_lo(b_lo), .b_hi(b_hi)
  );

  ovs_pair_walker #(.MAX_RANGES(MAX_RANGES)) u_walker (
    .clk(clk), .rst(rst),
    .init((state_q == SC_LOAD) && load_last),
    .step(state_q == SC_CMP),
    .cnt(cnt_q),
    .idx_i(idx_i), .idx_j(idx_j), .last(pair_last)
  );

  ovs_span_compare #(.PG_W(PG_W)) u_cmp (
    .a_vld(a_vld), .a_lo(a_lo), .a_hi(a_hi),
    .b_vld(b_vld), .b_lo(b_lo), .b_hi(b_hi),
    .hit(hit)
  );

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_ovl_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> !overlap);
  assert_ovl_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(overlap) |-> $past(state_q == SC_CMP));
  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(cnt_q));
  assert_read_range_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ({1'b0, rd_idx} < cnt_q));
endmodule

// File: tb/range_overlap_scanner_tb.sv
module range_overlap_scanner_tb;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] cap_word;
  logic        rd_en;
  logic [2:0]  rd_idx;
  logic [63:0] rd_base, rd_mask;
  logic        busy, done, overlap;

  logic [63:0] mb [NR];
  logic [63:0] mm [NR];

  always #4 clk = ~clk;  // 125 MHz

  assign rd_base = mb[rd_idx];
  assign rd_mask = mm[rd_idx];

  range_overlap_scanner u_dut (
    .clk(clk), .rst(rst), .start(start), .cap_word(cap_word),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_base(rd_base), .rd_mask(rd_mask),
    .busy(busy), .done(done), .overlap(overlap)
  );

  typedef struct {
    bit    ovl;
    int    lat;
    int    loads;
    int    stamp;
    string tag;
  } item_t;

  item_t sb[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  int    loads    = 0;
  bit    prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench-side model of bounds (R1, R2)
  task automatic bounds(input logic [63:0] b, input logic [63:0] m,
                        output bit v, output logic [24:0] lo, output logic [24:0] hi);
    v  = m[11];
    lo = '0;
    hi = '0;
    if (v) begin
      lo = {1'b0, b[35:12]};
      hi = lo + (25'h100_0000 - {1'b0, m[35:12]}) - 25'd1;
    end
  endtask

  function automatic bit inside_rng(logic [24:0] x, logic [24:0] lo, logic [24:0] hi);
    return (x >= lo) && (x <= hi);
  endfunction

  task automatic model(input int cap, output bit ovl, output int lat, output int nl);
    int eff;
    int idx;
    int stop_p;
    bit va, vb;
    logic [24:0] al, ah, bl, bh;
    eff = (cap > NR) ? NR : cap;
    ovl = 1'b0;
    if (eff < 2) begin
      lat = 1;
      nl  = 0;
      return;
    end
    idx = 0;
    stop_p = -1;
    for (int i = 0; i < eff; i++) begin
      for (int j = i + 1; j < eff; j++) begin
        if (!ovl) begin
          bounds(mb[i], mm[i], va, al, ah);
          bounds(mb[j], mm[j], vb, bl, bh);
          if (va && vb && (inside_rng(bl, al, ah) || inside_rng(bh, al, ah) ||
                           inside_rng(al, bl, bh) || inside_rng(ah, bl, bh))) begin
            ovl = 1'b1;
            stop_p = idx;
          end
          idx++;
        end
      end
    end
    if (!ovl) stop_p = idx - 1;
    lat = eff + 2 + stop_p;
    nl  = eff;
  endtask

  // descriptor with 2^k pages at page pg
  task automatic put(input int e, input int pg, input int k, input bit v);
    mb[e] = (64'(pg) << 12) | 64'h6;
    mm[e] = (64'hF_FFFF_F000 & ~((64'd1 << (k + 12)) - 64'd1)) | (64'(v) << 11);
  endtask

  task automatic clear_bank();
    for (int e = 0; e < NR; e++) begin
      mb[e] = 64'h0;
      mm[e] = 64'h0;
    end
  endtask

  // driver: predict, push, start; optional stray start while busy
  task automatic run_scan(input int cap, input string tag, input bit stray);
    item_t it;
    int nl;
    model(cap, it.ovl, it.lat, nl);
    it.loads = nl;
    it.tag   = tag;
    @(negedge clk);
    while (busy) @(negedge clk);
    cap_word   = 32'hABCD_0000 | 32'(cap);
    it.stamp   = cyc;
    sb.push_back(it);
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
    chk(overlap == 1'b0, "R6 overlap cleared on accept", overlap, 0);
    if (stray && busy) begin
      start = 1'b1;
      cap_word = 32'h0000_0001;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(overlap == it.ovl, {"R6 overlap held ", tag}, overlap, it.ovl);
  endtask

  // monitor: reads, done pulses, scoreboard compare
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en) begin
        chk(int'(rd_idx) == loads, "R10 read index order", rd_idx, loads);
        loads++;
      end
      if (prev_done) chk(done == 1'b0, "R6 done single cycle", done, 0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(overlap == it.ovl, {"R4/R5 result ", it.tag}, overlap, it.ovl);
          chk((cyc - it.stamp) == it.lat, {"R8 latency ", it.tag}, cyc - it.stamp, it.lat);
          chk(loads == it.loads, {"R10 read count ", it.tag}, loads, it.loads);
        end
        loads = 0;
      end
      prev_done = done;
    end
  end

  initial begin
    #800000;
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    cap_word = 32'd8;
    clear_bank();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(done == 1'b0, "R9 done after reset", done, 0);
    chk(overlap == 1'b0, "R9 overlap after reset", overlap, 0);
    chk(rd_en == 1'b0, "R9 rd_en after reset", rd_en, 0);

    // R1: all disabled
    run_scan(8, "all disabled", 1'b0);

    // R5: disjoint pair
    put(0, 16, 4, 1'b1);
    put(1, 64, 4, 1'b1);
    run_scan(8, "disjoint", 1'b0);

    // R5: touching at one page -> conflict
    put(1, 31, 0, 1'b1);
    run_scan(8, "touching", 1'b0);

    // R5: adjacent -> no conflict
    put(1, 32, 0, 1'b1);
    run_scan(8, "adjacent", 1'b0);

    // R1: disabled descriptor whose bounds would collide
    put(3, 20, 2, 1'b0);
    run_scan(8, "disabled inside", 1'b0);

    // R4: nested pair at (2,5), early stop
    clear_bank();
    put(2, 100, 6, 1'b1);
    put(5, 110, 1, 1'b1);
    put(6, 120, 0, 1'b1);
    run_scan(8, "nested 2-5", 1'b0);

    // R3: count limits past the conflict
    run_scan(4, "count 4 hides entry 5", 1'b0);
    run_scan(1, "count 1", 1'b0);
    run_scan(0, "count 0", 1'b0);
    run_scan(200, "count clamped", 1'b0);

    // R2: all-zero mask field spans every page
    clear_bank();
    mb[0] = 64'h0;
    mm[0] = 64'h800;
    put(7, 24'hFFFFF0, 0, 1'b1);
    run_scan(8, "full span", 1'b0);

    // R2: bits above the address width in base ignored
    clear_bank();
    put(0, 40, 3, 1'b1);
    put(1, 44, 0, 1'b1);
    mb[1] = mb[1] | 64'hFFF0_0000_0000_0000;
    run_scan(2, "high base bits", 1'b0);

    // R7: stray start while busy
    clear_bank();
    put(3, 7, 2, 1'b1);
    put(4, 9, 0, 1'b1);
    run_scan(8, "stray start", 1'b1);
    run_scan(6, "stray start no hit", 1'b1);

    // mixed patterns
    for (int t = 0; t < 30; t++) begin
      for (int e = 0; e < NR; e++)
        put(e, int'($urandom_range(0, 300)), int'($urandom_range(0, 5)),
            ($urandom_range(0, 3) != 0));
      run_scan(int'($urandom_range(0, 10)), "mixed R5", (t % 4) == 1);
    end

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule